// File: doc/BRIEF.md
# Resonant Tank Tuning Controller

This block closes the digital half of a supply regulation loop for a chip powered through an inductive link. The receiving LC tank has a bank of switchable capacitors in parallel, weighted in powers of two. A larger bank code adds capacitance and a smaller one removes it, which moves the tank towards or away from resonance and so changes the rectified voltage. The controller sets that code. It does not count towards a known setpoint. Instead it makes a small change to the code and then watches the effect, a perturb-and-observe search.

Each regulation round has four phases in a fixed order. First an auto-zero strobe goes out, then a sample strobe that captures the rectified voltage. Next the code moves by exactly one, and last the comparator's verdict is taken in. That verdict says whether the voltage rose or fell because of the step. Three supply-level flags mark about 1.0 V, 1.3 V and 1.5 V. While the 1.5 V flag is low the supply should go up, and while it is high the supply should come down. The controller keeps stepping the same way while the observed change matches that wish, and it turns round when the change does not match. Load-shift-keying backscatter is permitted only while the supply is above both upper thresholds. The loop is meant to run from a regulation clock of about 846 kHz.

Top module: `tank_tune_ctrl`

## Requirements
- R1: While rst_ni is low, cap_code_o equals CODE_RST (default 32), and azero_o, sample_o and lsk_en_o are all 0.
- R2: While lvl_1v0_i is high, the strobes follow the order idle, azero_o, sample_o, step, observe, then repeat from azero_o without passing through idle again. azero_o and sample_o are each high for exactly one cycle per round. The code changes only on the clock edge that ends the step phase, which is the cycle after sample_o.
- R3: On each step edge with the supply good, cap_code_o moves by exactly +1 or -1.
- R4: The first step after reset or after a supply drop follows the wanted trend: up when lvl_1v5_i is 0, down when lvl_1v5_i is 1.
- R5: On later steps the direction of the previous step is kept when the latched comparator value equals the wanted trend, and it is reversed otherwise. Comparator encoding: cmp_rise_i = 1 means the rectified voltage rose. The comparator is latched on the edge that ends the observe phase.
- R6: The code never wraps. A step taken at full scale (all ones) goes down, and a step taken at zero goes up.
- R7: While lvl_1v0_i is low, cap_code_o is forced to CODE_RST on the next edge, the sequencer returns to idle with no strobes, and the direction history is dropped.
- R8: lsk_en_o is 1 in the cycle after an edge at which lvl_1v0_i, lvl_1v3_i and lvl_1v5_i were all 1. Otherwise it is 0.
- R9: When driven by a tank whose voltage crosses 1.5 V within the code range, the loop settles, and the voltage then stays within ±100 mV of 1.5 V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Regulation clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_rise_i | input | 1 | Comparator: 1 when the rectified voltage rose after the last step |
| lvl_1v0_i | input | 1 | Supply above about 1.0 V (loop may run) |
| lvl_1v3_i | input | 1 | Supply above about 1.3 V |
| lvl_1v5_i | input | 1 | Supply at or above the 1.5 V target |
| cap_code_o | output | CODE_W | Capacitor bank code |
| azero_o | output | 1 | Amplifier auto-zero strobe |
| sample_o | output | 1 | Rectified-voltage sample strobe |
| lsk_en_o | output | 1 | Backscatter permitted |

## Verification
The hardest condition to reach from the ports is the code sitting at a rail with the forced turn-round happening. The comparator input must then agree with a tank whose voltage keeps improving towards that rail, round after round, for dozens of rounds. Random comparator bits almost never produce such a run. The bench therefore closes the loop through behavioural tank models that map the code to a voltage. Two models place the resonance so that the target is crossed on opposite sides of the start code. Two more place an unreachable peak at full scale and at zero, which drives the search into each limit. Random flag and comparator traffic, with occasional supply drops, covers the direction rule in between.

// File: rtl/tank_tune_pkg.sv
package tank_tune_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_AZERO   = 3'd1,
    PH_SAMPLE  = 3'd2,
    PH_STEP    = 3'd3,
    PH_OBSERVE = 3'd4
  } reg_phase_e;

endpackage

// File: rtl/tune_phase_seq.sv
module tune_phase_seq
  import tank_tune_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  output logic azero_o,
  output logic sample_o,
  output logic step_en_o,
  output logic obs_en_o
);

  reg_phase_e phase_q, phase_d;

  always_comb begin
    phase_d = PH_IDLE;
    if (supply_ok_i) begin
      case (phase_q)
        PH_IDLE:    phase_d = PH_AZERO;
        PH_AZERO:   phase_d = PH_SAMPLE;
        PH_SAMPLE:  phase_d = PH_STEP;
        PH_STEP:    phase_d = PH_OBSERVE;
        PH_OBSERVE: phase_d = PH_AZERO;
        default:    phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign azero_o   = (phase_q == PH_AZERO);
  assign sample_o  = (phase_q == PH_SAMPLE);
  assign step_en_o = (phase_q == PH_STEP);
  assign obs_en_o  = (phase_q == PH_OBSERVE);

  // R2: sampling always follows an auto-zero cycle
  p_sample_after_az_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> $past(azero_o));

  // R2: the code step always follows the sample cycle
  p_step_after_sample_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_en_o |-> $past(sample_o));

endmodule

// File: rtl/tune_dir_pick.sv
module tune_dir_pick (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic obs_en_i,
  input  logic step_en_i,
  input  logic cmp_rise_i,
  input  logic want_up_i,
  input  logic at_max_i,
  input  logic at_min_i,
  output logic go_up_o
);

  logic dir_q, dir_d;
  logic obs_q, obs_d;
  logic vld_q, vld_d;
  logic trend_up;

  // hill-climb rule, then rail override
  always_comb begin
    if (!vld_q)                    trend_up = want_up_i;
    else if (obs_q == want_up_i)   trend_up = dir_q;
    else                           trend_up = ~dir_q;
    if (at_max_i)                  go_up_o = 1'b0;
    else if (at_min_i)             go_up_o = 1'b1;
    else                           go_up_o = trend_up;
  end

  always_comb begin
    dir_d = dir_q;
    obs_d = obs_q;
    vld_d = vld_q;
    if (!supply_ok_i) begin
      dir_d = 1'b1;
      obs_d = 1'b0;
      vld_d = 1'b0;
    end else begin
      if (obs_en_i) begin
        obs_d = cmp_rise_i;
        vld_d = 1'b1;
      end
      if (step_en_i) dir_d = go_up_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= 1'b1;
      obs_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      dir_q <= dir_d;
      obs_q <= obs_d;
      vld_q <= vld_d;
    end
  end

  // R7: a supply drop clears the observation history
  p_drop_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> !vld_q);

endmodule

// File: rtl/tune_cap_reg.sv
module tune_cap_reg #(
  parameter int CODE_W   = 6,
  parameter int CODE_RST = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              supply_ok_i,
  input  logic              step_en_i,
  input  logic              go_up_i,
  output logic [CODE_W-1:0] code_o,
  output logic              at_max_o,
  output logic              at_min_o
);

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_INI = CODE_W'(CODE_RST);
  localparam logic [CODE_W-1:0] ONE      = CODE_W'(1);

  logic [CODE_W-1:0] code_q, code_d;

  assign at_max_o = (code_q == CODE_MAX);
  assign at_min_o = (code_q == '0);

  always_comb begin
    code_d = code_q;
    if (!supply_ok_i) begin
      code_d = CODE_INI;
    end else if (step_en_i) begin
      if (go_up_i) code_d = at_max_o ? code_q : code_q + ONE;
      else         code_d = at_min_o ? code_q : code_q - ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= CODE_INI;
    else         code_q <= code_d;
  end

  assign code_o = code_q;

  // R3: each step moves the code by exactly one
  p_unit_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(step_en_i && supply_ok_i) |->
      (((code_q - $past(code_q)) == ONE) || ((code_q - $past(code_q)) == CODE_MAX)));

  // R2: with the supply good the code moves only on a step edge
  p_code_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(supply_ok_i) && !$past(step_en_i)) |-> $stable(code_q));

  // R6: full scale turns down instead of wrapping
  p_no_wrap_top_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(step_en_i && supply_ok_i && (code_q == CODE_MAX)) |-> (code_q == CODE_MAX - ONE));

  // R6: zero turns up instead of wrapping
  p_no_wrap_bot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(step_en_i && supply_ok_i && (code_q == '0)) |-> (code_q == ONE));

  // R7: a low supply returns the bank to its start code
  p_hold_rst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (code_q == CODE_INI));

endmodule

// File: rtl/tank_tune_ctrl.sv
module tank_tune_ctrl #(
  parameter int CODE_W   = 6,
  parameter int CODE_RST = 2 ** (CODE_W - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_rise_i,
  input  logic              lvl_1v0_i,
  input  logic              lvl_1v3_i,
  input  logic              lvl_1v5_i,
  output logic [CODE_W-1:0] cap_code_o,
  output logic              azero_o,
  output logic              sample_o,
  output logic              lsk_en_o
);

  logic step_en, obs_en, go_up, at_max, at_min;
  logic lsk_q, lsk_d;

  tune_phase_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .supply_ok_i (lvl_1v0_i),
    .azero_o     (azero_o),
    .sample_o    (sample_o),
    .step_en_o   (step_en),
    .obs_en_o    (obs_en)
  );

  tune_dir_pick u_dir (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .supply_ok_i (lvl_1v0_i),
    .obs_en_i    (obs_en),
    .step_en_i   (step_en),
    .cmp_rise_i  (cmp_rise_i),
    .want_up_i   (~lvl_1v5_i),
    .at_max_i    (at_max),
    .at_min_i    (at_min),
    .go_up_o     (go_up)
  );

  tune_cap_reg #(
    .CODE_W   (CODE_W),
    .CODE_RST (CODE_RST)
  ) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .supply_ok_i (lvl_1v0_i),
    .step_en_i   (step_en),
    .go_up_i     (go_up),
    .code_o      (cap_code_o),
    .at_max_o    (at_max),
    .at_min_o    (at_min)
  );

  assign lsk_d = lvl_1v0_i & lvl_1v3_i & lvl_1v5_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lsk_q <= 1'b0;
    else         lsk_q <= lsk_d;
  end

  assign lsk_en_o = lsk_q;

  // R8: backscatter only after both upper thresholds were seen
  p_lsk_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsk_en_o |-> $past(lvl_1v5_i && lvl_1v3_i));

  // R8: backscatter withdrawn after a below-target cycle
  p_lsk_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lvl_1v5_i |=> !lsk_en_o);

endmodule

// File: tb/tank_tune_ctrl_tb_top.sv
module tank_tune_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CW   = 6;
  localparam int CRST = 32;
  localparam int CMAX = 63;

  logic          clk, rst_n;
  logic          cmp_rise, f1, f3, f5;
  logic [CW-1:0] code;
  logic          azero, sample, lsk;

  int n_chk, n_bad;
  bit done;

  // reference state
  int m_phase, m_code, m_dir, m_vld, m_obs, m_lsk;

  tank_tune_ctrl #(.CODE_W(CW), .CODE_RST(CRST)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmp_rise_i(cmp_rise),
    .lvl_1v0_i(f1), .lvl_1v3_i(f3), .lvl_1v5_i(f5),
    .cap_code_o(code), .azero_o(azero), .sample_o(sample), .lsk_en_o(lsk)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  // reference update for one rising edge (phases: 0 idle,1 az,2 smp,3 step,4 obs)
  task automatic model_edge(input bit c, input bit a1, input bit a3, input bit a5);
    int nd;
    m_lsk = (a1 && a3 && a5) ? 1 : 0;
    if (!a1) begin
      m_code = CRST; m_dir = 1; m_vld = 0; m_obs = 0; m_phase = 0;
      return;
    end
    if (m_phase == 3) begin
      if (m_vld == 0)                 nd = a5 ? 0 : 1;
      else if (m_obs == (a5 ? 0 : 1)) nd = m_dir;
      else                            nd = 1 - m_dir;
      if (m_code == CMAX)   nd = 0;
      else if (m_code == 0) nd = 1;
      m_code = nd ? m_code + 1 : m_code - 1;
      m_dir  = nd;
    end
    if (m_phase == 4) begin
      m_obs = c; m_vld = 1;
    end
    m_phase = (m_phase == 4) ? 1 : m_phase + 1;
  endtask

  task automatic cycle(input bit c, input bit a1, input bit a3, input bit a5, input string ctag);
    cmp_rise = c; f1 = a1; f3 = a3; f5 = a5;
    @(posedge clk);
    model_edge(c, a1, a3, a5);
    @(negedge clk);
    check({ctag, " code"}, int'(code), m_code);
    check("R2 azero", int'(azero), (m_phase == 1) ? 1 : 0);
    check("R2 sample", int'(sample), (m_phase == 2) ? 1 : 0);
    check("R8 lsk", int'(lsk), m_lsk);
  endtask

  function automatic int tank_mv(input int cd, input int pk, input int peak, input int slope);
    int d;
    d = (cd > pk) ? cd - pk : pk - cd;
    return peak - slope * d;
  endfunction

  // closed loop with a behavioural tank
  task automatic tank_run(input int pk, input int peak, input int slope, input int n,
                          input bit settle, output int cmin, output int cmax);
    int v, v_smp, vlo, vhi;
    bit c;
    for (int i = 0; i < 2; i++) cycle(1'b0, 1'b0, 1'b0, 1'b0, "R7");
    v_smp = tank_mv(CRST, pk, peak, slope);
    vlo = 99999; vhi = -99999; cmin = 999; cmax = -1;
    for (int i = 0; i < n; i++) begin
      v = tank_mv(int'(code), pk, peak, slope);
      if (sample) v_smp = v;
      c = (v > v_smp);
      if (i >= n - 80) begin
        if (v < vlo) vlo = v;
        if (v > vhi) vhi = v;
      end
      if (int'(code) < cmin) cmin = int'(code);
      if (int'(code) > cmax) cmax = int'(code);
      cycle(c, v >= 1000, v >= 1300, v >= 1500, "R5");
    end
    if (settle) begin
      check("R9 settled low mV", (vlo >= 1400) ? vlo : 0, vlo);
      check("R9 settled high mV", (vhi <= 1600) ? vhi : 0, vhi);
    end
  endtask

  initial begin
    int cmn, cmx;
    n_chk = 0; n_bad = 0; done = 0;
    m_phase = 0; m_code = CRST; m_dir = 1; m_vld = 0; m_obs = 0; m_lsk = 0;
    void'($urandom(32'h1c0de5));
    rst_n = 1'b0; cmp_rise = 1'b0; f1 = 1'b1; f3 = 1'b1; f5 = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 code", int'(code), CRST);
    check("R1 azero", int'(azero), 0);
    check("R1 sample", int'(sample), 0);
    check("R1 lsk", int'(lsk), 0);
    rst_n = 1'b1;

    // R4: first step follows the wanted trend (down when at target)
    for (int i = 0; i < 4; i++) cycle(1'b1, 1'b1, 1'b1, 1'b1, "R4");
    check("R4 first step down", int'(code), CRST - 1);
    for (int i = 0; i < 2; i++) cycle(1'b0, 1'b0, 1'b1, 1'b1, "R7");
    check("R7 hold code", int'(code), CRST);
    check("R7 no strobe", int'(azero) + int'(sample), 0);
    check("R7 lsk off", int'(lsk), 0);
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1, 1'b0, 1'b0, "R4");
    check("R4 first step up", int'(code), CRST + 1);

    // R5: matching polarity keeps direction, mismatch reverses
    for (int i = 0; i < 4; i++) cycle(1'b1, 1'b1, 1'b0, 1'b0, "R5");
    check("R5 keep up", int'(code), CRST + 2);
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1, 1'b0, 1'b0, "R5");
    check("R5 reverse", int'(code), CRST + 1);

    // R9: resonance above start code and below it
    tank_run(50, 1900, 15, 500, 1'b1, cmn, cmx);
    tank_run(10, 1900, 15, 500, 1'b1, cmn, cmx);

    // R6: target unreachable, peak at each rail
    tank_run(CMAX, 1450, 5, 600, 1'b0, cmn, cmx);
    check("R6 reached full scale", cmx, CMAX);
    check("R6 turned from full scale", int'(code) >= CMAX - 1 ? 1 : 0, 1);
    tank_run(0, 1450, 5, 600, 1'b0, cmn, cmx);
    check("R6 reached zero", cmn, 0);
    check("R6 turned from zero", int'(code) <= 1 ? 1 : 0, 1);

    // random flags and comparator, occasional supply loss (R3 R5 R7 R8)
    for (int i = 0; i < 4000; i++) begin
      bit r1;
      r1 = ($urandom % 16) != 0;
      cycle(1'($urandom), r1, 1'($urandom), 1'($urandom), r1 ? "R3" : "R7");
    end

    summary();
    $finish;
  end

endmodule